// File: doc/BRIEF.md
# Compressor-Tree 8x8 Unsigned Multiplier

This block multiplies two 8-bit unsigned operands and returns their full 16-bit product. All 64 single-bit partial products are formed with AND gates. Each product bit is placed in the column equal to the sum of its two operand bit indices. The resulting matrix is then reduced to two rows in two layers of carry-save cells. The first layer turns eight rows into four and the second turns four rows into two. A single carry-propagate adder adds the last two rows.

Each reduction layer picks a cell for every column from the number of live bits in that column. Four-high columns use a 4:2 compressor, which passes a lateral carry into the next column. A three-high column that receives such a lateral carry also uses a 4:2 compressor. Shorter edge columns use a full adder, a half adder or a plain wire. The 4:2 compressor is two cascaded full adders, and its lateral carry-out does not depend on its carry-in, so the lateral chain never ripples further than one column.

A parameter selects an output register. The register is reset asynchronously, and a two-stage synchronizer releases the reset on a clock edge. The default build has the register, so a result appears on the first rising edge after its operands are presented.

Top module: `wtm_mul8`

## Requirements
- R1: With the output register enabled, `prod` equals `op_a * op_b` as unsigned numbers for every one of the 65536 operand pairs. The product is the one for the operands present at the previous rising edge of `clk`.
- R2: Product bit 0 always equals `op_a[0] & op_b[0]`.
- R3: A partial product `op_a[i] & op_b[j]` carries weight 2^(i+j). With `op_a = 1<<i` and `op_b = 1<<j`, the product is `1<<(i+j)` for every i, j in 0..7.
- R4: The two rows left after the second layer add, modulo 2^16, to the product of the operands.
- R5: For all 32 input combinations of the 4:2 cell, `sum + 2*(carry + cout)` equals the number of ones among its four data inputs and its carry-in.
- R6: The 4:2 cell's `cout` stays the same when only its carry-in changes.
- R7: While `rst_n` is low, `prod` reads zero. After release, the output register captures a new product on every rising edge.
- R8: The four rows left after the first layer add, modulo 2^16, to the product of the operands.
- R9: Boundary operands give exact results: a zero operand gives 0, and 255 times 255 gives 65025 (0xFE01) with no lost carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register and the reset synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| prod | output | 16 | Unsigned product, registered by default |

## Verification
Some properties are checked on every clock edge after reset: the arithmetic value of the rows after each reduction layer, the direct path of product bit 0, and the one-edge delay through the output register. The weighted-sum identity of each 4:2 cell is checked whenever its inputs change. Other behaviours can only be shown by the bench's scenarios. These are the zero output during reset, the placement of single partial products through one-hot operands, the boundary operands, and the full exhaustive sweep of operand pairs. The cell's carry-in independence also needs the bench, which drives a standalone 4:2 cell through all 32 input combinations and through carry-in toggles.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
  // Rows fed to one reduction cell group and rows leaving it.
  localparam int unsigned GRP_IN  = 4;
  localparam int unsigned GRP_OUT = 2;
  // Width of one packed range entry describing a row's live columns.
  localparam int unsigned RNG_W   = 8;

  function automatic int unsigned clip(int unsigned v, int unsigned top);
    return (v > top) ? top : v;
  endfunction
endpackage

// File: rtl/wtm_cmp42.sv
module wtm_cmp42 (
  input  logic x0,
  input  logic x1,
  input  logic x2,
  input  logic x3,
  input  logic cin,
  output logic sum,
  output logic carry,
  output logic cout
);
  logic mid;

  // First full adder: lateral carry depends only on x0..x2.
  always_comb begin
    mid  = x0 ^ x1 ^ x2;
    cout = (x0 & x1) | (x0 & x2) | (x1 & x2);
  end

  // Second full adder folds in x3 and the incoming lateral carry.
  always_comb begin
    sum   = mid ^ x3 ^ cin;
    carry = (mid & x3) | (mid & cin) | (x3 & cin);
  end

  // R5: weighted outputs equal the count of ones on the five inputs.
  always_comb begin
    p_cell_weight_r5: assert ((3'(sum) + 3'd2 * (3'(carry) + 3'(cout))) ==
                              (3'(x0) + 3'(x1) + 3'(x2) + 3'(x3) + 3'(cin)))
      else $error("4:2 cell weight mismatch");
  end
endmodule

// File: rtl/wtm_csa.sv
module wtm_csa #(
  parameter bit HALF = 1'b0
) (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  if (HALF) begin : g_ha
    assign s = x ^ y;
    assign c = x & y;
    logic unused_z;
    assign unused_z = z;
  end else begin : g_fa
    assign s = x ^ y ^ z;
    assign c = (x & y) | (x & z) | (y & z);
  end
endmodule

// File: rtl/wtm_ppgen.sv
module wtm_ppgen #(
  parameter int unsigned OPW = 8,
  localparam int unsigned PW = 2 * OPW
) (
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  output logic [PW-1:0]  pp [OPW]
);
  // Row j holds a AND b[j], shifted so bit a[i] lands in column i+j.
  for (genvar j = 0; j < OPW; j++) begin : g_row
    assign pp[j] = PW'(a & {OPW{b[j]}}) << j;
  end
endmodule

// File: rtl/wtm_layer.sv
module wtm_layer
  import wtm_pkg::*;
#(
  parameter int unsigned W  = 16,
  // Byte k gives the lowest / highest column row k may occupy.
  parameter logic [GRP_IN*RNG_W-1:0] LO = '0,
  parameter logic [GRP_IN*RNG_W-1:0] HI = '0
) (
  input  logic [W-1:0] rows  [GRP_IN],
  output logic [W-1:0] sum_o,
  output logic [W-1:0] car_o
);
  function automatic bit is_live(int k, int c);
    return (c >= int'(LO[RNG_W*k +: RNG_W])) && (c <= int'(HI[RNG_W*k +: RNG_W]));
  endfunction

  function automatic int height(int c);
    int n;
    n = 0;
    for (int k = 0; k < int'(GRP_IN); k++)
      if (is_live(k, c)) n++;
    return n;
  endfunction

  // Column uses a compressor when four-high, or three-high fed by a lateral carry.
  function automatic bit is_cmp(int c);
    bit ch;
    int n;
    ch = 1'b0;
    for (int q = 0; q <= c; q++) begin
      n  = height(q);
      ch = (n == 4) || ((n == 3) && ch);
    end
    return ch;
  endfunction

  // Index of the j-th live row in column c.
  function automatic int pick(int c, int j);
    int seen;
    int res;
    seen = 0;
    res  = 0;
    for (int k = 0; k < int'(GRP_IN); k++) begin
      if (is_live(k, c)) begin
        if (seen == j) res = k;
        seen++;
      end
    end
    return res;
  endfunction

  logic [W-1:0] srow;
  logic [W:0]   cry;
  logic [W:0]   chn;

  assign cry[0] = 1'b0;
  assign chn[0] = 1'b0;

  for (genvar c = 0; c < int'(W); c++) begin : g_col
    localparam int N  = height(c);
    localparam bit CH = (c > 0) && is_cmp(c - 1);
    localparam bit CM = is_cmp(c);
    localparam int M  = N + (CH ? 1 : 0);

    logic [3:0] xs;
    for (genvar j = 0; j < 4; j++) begin : g_in
      if (j < N) begin : g_row
        localparam int PK = pick(c, j);
        assign xs[j] = rows[PK][c];
      end else if ((j == N) && CH) begin : g_lat
        assign xs[j] = chn[c];
      end else begin : g_nil
        assign xs[j] = 1'b0;
      end
    end

    if (CM) begin : g_cmp
      logic cin_sel;
      assign cin_sel = (N == 4) ? chn[c] : 1'b0;
      wtm_cmp42 u_cmp (
        .x0(xs[0]), .x1(xs[1]), .x2(xs[2]), .x3(xs[3]), .cin(cin_sel),
        .sum(srow[c]), .carry(cry[c+1]), .cout(chn[c+1])
      );
    end else begin : g_edge
      assign chn[c+1] = 1'b0;
      if (M == 3) begin : g_fa
        wtm_csa #(.HALF(1'b0)) u_fa (
          .x(xs[0]), .y(xs[1]), .z(xs[2]), .s(srow[c]), .c(cry[c+1])
        );
      end else if (M == 2) begin : g_ha
        wtm_csa #(.HALF(1'b1)) u_ha (
          .x(xs[0]), .y(xs[1]), .z(1'b0), .s(srow[c]), .c(cry[c+1])
        );
      end else if (M == 1) begin : g_wire
        assign srow[c]  = xs[0];
        assign cry[c+1] = 1'b0;
      end else begin : g_empty
        assign srow[c]  = 1'b0;
        assign cry[c+1] = 1'b0;
      end
    end

    logic unused_xs;
    assign unused_xs = ^xs;
  end

  assign sum_o = srow;
  assign car_o = cry[W-1:0];

  logic unused_top;
  assign unused_top = cry[W] ^ chn[W] ^ (^{rows[0], rows[1], rows[2], rows[3]});
endmodule

// File: rtl/wtm_cpa.sv
module wtm_cpa #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  // Carry-propagate stage; the adder architecture is left to synthesis.
  assign s = x + y;
endmodule

// File: rtl/wtm_mul8.sv
module wtm_mul8
  import wtm_pkg::*;
#(
  parameter int unsigned OPW     = 8,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned PW     = 2 * OPW,
  localparam int unsigned NG     = OPW / GRP_IN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic [PW-1:0]  prod
);
  // Live column ranges of the four rows entering first-layer group g.
  function automatic logic [GRP_IN*RNG_W-1:0] grp_lo(int g);
    logic [GRP_IN*RNG_W-1:0] v;
    for (int k = 0; k < int'(GRP_IN); k++)
      v[RNG_W*k +: RNG_W] = RNG_W'(GRP_IN * g + k);
    return v;
  endfunction

  function automatic logic [GRP_IN*RNG_W-1:0] grp_hi(int g);
    logic [GRP_IN*RNG_W-1:0] v;
    for (int k = 0; k < int'(GRP_IN); k++)
      v[RNG_W*k +: RNG_W] = RNG_W'(GRP_IN * g + k + OPW - 1);
    return v;
  endfunction

  // Second-layer inputs: (sum, carry) of each first-layer group, superset ranges.
  function automatic logic [GRP_IN*RNG_W-1:0] st2_lo();
    logic [GRP_IN*RNG_W-1:0] v;
    for (int g = 0; g < int'(NG); g++) begin
      v[RNG_W*(2*g)   +: RNG_W] = RNG_W'(GRP_IN * g);
      v[RNG_W*(2*g+1) +: RNG_W] = RNG_W'(GRP_IN * g + 1);
    end
    return v;
  endfunction

  function automatic logic [GRP_IN*RNG_W-1:0] st2_hi();
    logic [GRP_IN*RNG_W-1:0] v;
    for (int g = 0; g < int'(NG); g++) begin
      v[RNG_W*(2*g)   +: RNG_W] = RNG_W'(clip(GRP_IN * g + OPW + 2, PW - 1));
      v[RNG_W*(2*g+1) +: RNG_W] = RNG_W'(clip(GRP_IN * g + OPW + 3, PW - 1));
    end
    return v;
  endfunction

  logic [PW-1:0] pp     [OPW];
  logic [PW-1:0] s1_sum [NG];
  logic [PW-1:0] s1_car [NG];
  logic [PW-1:0] st2_in [GRP_IN];
  logic [PW-1:0] st2_sum;
  logic [PW-1:0] st2_car;
  logic [PW-1:0] prod_c;

  wtm_ppgen #(.OPW(OPW)) u_pp (.a(op_a), .b(op_b), .pp(pp));

  // First layer: each group of four partial-product rows becomes two rows.
  for (genvar g = 0; g < int'(NG); g++) begin : g_l1
    logic [PW-1:0] gin [GRP_IN];
    for (genvar k = 0; k < int'(GRP_IN); k++) begin : g_sel
      assign gin[k] = pp[GRP_IN*g + k];
    end
    wtm_layer #(.W(PW), .LO(grp_lo(g)), .HI(grp_hi(g))) u_lay (
      .rows(gin), .sum_o(s1_sum[g]), .car_o(s1_car[g])
    );
    assign st2_in[GRP_OUT*g]     = s1_sum[g];
    assign st2_in[GRP_OUT*g + 1] = s1_car[g];
  end

  // Second layer: four rows become the final two.
  wtm_layer #(.W(PW), .LO(st2_lo()), .HI(st2_hi())) u_l2 (
    .rows(st2_in), .sum_o(st2_sum), .car_o(st2_car)
  );

  wtm_cpa #(.W(PW)) u_cpa (.x(st2_sum), .y(st2_car), .s(prod_c));

  if (REG_OUT) begin : g_reg
    logic [1:0]    rs_q;
    logic          rst_sync;
    logic [PW-1:0] prod_d;
    logic [PW-1:0] prod_q;

    // Reset asserts at once and releases after two clock edges.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rs_q <= '0;
      else        rs_q <= {rs_q[0], 1'b1};
    end
    assign rst_sync = rs_q[1];

    always_comb begin
      prod_d = prod_c;
    end

    always_ff @(posedge clk or negedge rst_sync) begin
      if (!rst_sync) prod_q <= '0;
      else           prod_q <= prod_d;
    end

    assign prod = prod_q;

    // Checker state: one capture edge has passed since release.
    logic seen_q;
    always_ff @(posedge clk or negedge rst_sync) begin
      if (!rst_sync) seen_q <= 1'b0;
      else           seen_q <= 1'b1;
    end

    logic [PW-1:0] ref_p;
    assign ref_p = PW'(op_a) * PW'(op_b);

    p_bit0_direct_r2: assert property (@(posedge clk) disable iff (!rst_sync)
      prod_c[0] == (op_a[0] & op_b[0]))
      else $error("product bit 0 not equal to a0&b0");

    p_final_rows_r4: assert property (@(posedge clk) disable iff (!rst_sync)
      PW'(st2_sum + st2_car) == ref_p)
      else $error("second-layer rows do not sum to the product");

    p_first_rows_r8: assert property (@(posedge clk) disable iff (!rst_sync)
      PW'(s1_sum[0] + s1_car[0] + s1_sum[NG-1] + s1_car[NG-1]) == ref_p)
      else $error("first-layer rows do not sum to the product");

    p_one_edge_r7: assert property (@(posedge clk) disable iff (!rst_sync)
      seen_q |-> (prod == $past(ref_p)))
      else $error("registered product does not match previous operands");
  end else begin : g_comb
    assign prod = prod_c;
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
  end
endmodule

// File: tb/sim_wtm_mul8.sv
`timescale 1ns/1ps
module sim_wtm_mul8;
  typedef struct {
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [7:0]  op_a;
  logic [7:0]  op_b;
  logic [15:0] prod;

  logic [4:0]  cv;
  logic        c_sum, c_car, c_cout;

  item_t       sbq[$];
  int          n_chk;
  int          n_fail;
  bit          done;

  wtm_mul8 u0 (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod));

  wtm_cmp42 u_cell (
    .x0(cv[0]), .x1(cv[1]), .x2(cv[2]), .x3(cv[3]), .cin(cv[4]),
    .sum(c_sum), .carry(c_car), .cout(c_cout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic drive(input logic [7:0] a, input logic [7:0] b, input string tag);
    item_t it;
    @(negedge clk);
    op_a = a;
    op_b = b;
    it.a = a; it.b = b; it.tag = tag;
    it.exp = 16'(a) * 16'(b);
    sbq.push_back(it);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Monitor: each queued item shows one rising edge after it was driven.
  always @(posedge clk) begin
    item_t it;
    #1;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      n_chk++;
      if (prod !== it.exp) begin
        n_fail++;
        $display("FAIL %s: %0d*%0d actual %0d expected %0d", it.tag, it.a, it.b, prod, it.exp);
      end
      n_chk++;
      if (prod[0] !== (it.a[0] & it.b[0])) begin
        n_fail++;
        $display("FAIL R2: bit0 actual %0b expected %0b", prod[0], it.a[0] & it.b[0]);
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic cout0;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    op_a = 8'd200;
    op_b = 8'd3;
    cv = '0;

    // R5: exhaustive weighted-sum check of the 4:2 cell.
    for (int v = 0; v < 32; v++) begin
      cv = v[4:0];
      #1;
      n_chk++;
      if ((int'(c_sum) + 2 * (int'(c_car) + int'(c_cout))) != $countones(cv)) begin
        n_fail++;
        $display("FAIL R5: in=%b actual %0d expected %0d", cv,
                 int'(c_sum) + 2 * (int'(c_car) + int'(c_cout)), $countones(cv));
      end
    end

    // R6: lateral carry-out ignores carry-in.
    for (int v = 0; v < 16; v++) begin
      cv = {1'b0, v[3:0]};
      #1;
      cout0 = c_cout;
      cv = {1'b1, v[3:0]};
      #1;
      n_chk++;
      if (c_cout !== cout0) begin
        n_fail++;
        $display("FAIL R6: data=%b actual %b expected %b", v[3:0], c_cout, cout0);
      end
    end

    // R7: output held at zero while reset is asserted.
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (prod !== 16'd0) begin
      n_fail++;
      $display("FAIL R7: during reset actual %0d expected 0", prod);
    end

    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3: one-hot operands place a single bit in column i+j.
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        drive(8'(1 << i), 8'(1 << j), "R3");

    // R9: boundary operands.
    drive(8'd0,   8'd255, "R9");
    drive(8'd255, 8'd0,   "R9");
    drive(8'd255, 8'd255, "R9");
    drive(8'd1,   8'd255, "R9");

    // R1 with R4, R8 and R7 timing: exhaustive operand sweep.
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        drive(8'(a), 8'(b), "R1,R4,R8,R7");

    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (sbq.size() != 0) begin
      n_fail++;
      $display("FAIL R1: pending items actual %0d expected 0", sbq.size());
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule